// File: doc/BRIEF.md
# Bit-Serial Adder-Subtractor

This block adds or subtracts two WIDTH-bit operands one bit pair per clock through a single full adder. A start request copies both operands into their own shift registers. Each clock cycle after that, both registers shift right by one place. The low bit of X, the low bit of Y (passed through or inverted), and a stored carry go into the full adder. The sum bit enters the top of a result register, and the adder's carry-out is stored for the next, more significant pair.

Subtraction is done in two's complement on the same datapath. An AND-OR selector chooses either the plain Y bit or its inverse. The carry flip-flop starts at 1 for subtraction and at 0 for addition. A cycle counter ends the operation after WIDTH bit pairs and pulses done. The result and the final carry are then held until the next operation begins.

Top module: `bit_serial_addsub`

## Requirements
- R1: After reset, result_o is all zeros, carry_o is 0 and done_o is 0.
- R2: With sub_i = 0 at start, result_o is (x_i + y_i) mod 2^WIDTH and carry_o is bit WIDTH of the full sum.
- R3: With sub_i = 1 at start, result_o is (x_i - y_i) mod 2^WIDTH. carry_o is 1 exactly when x_i >= y_i as unsigned values. The stored carry is set to 1 on the start edge of a subtraction and to 0 on the start edge of an addition.
- R4: done_o is high for exactly one cycle. It rises on the WIDTH-th rising clock edge after the edge that accepted start.
- R5: A start_i pulse while an operation is in progress is ignored. The running operation's result, carry and done timing are unchanged, and its operands are not reloaded.
- R6: While idle and with start_i low, result_o and carry_o stay unchanged, whatever x_i, y_i and sub_i do.
- R7: A start_i asserted in the cycle where done_o is high is accepted, so operations can run back to back.
- R8: sub_i is sampled only on the edge that accepts start. Changing it during an operation has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to load operands and begin |
| sub_i | input | 1 | 0 = add, 1 = subtract; sampled with start |
| x_i | input | WIDTH | Augend or minuend load value |
| y_i | input | WIDTH | Addend or subtrahend load value |
| result_o | output | WIDTH | Sum or difference, valid from done |
| carry_o | output | 1 | Final carry flip-flop value, valid from done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the control side on every cycle:
- done_o is a single-cycle pulse.
- done_o arrives exactly WIDTH edges after the accepted start, which also covers starts that arrive while busy.
- The latched operation does not change mid-run.
- The stored carry is preset from sub_i on the start edge.
- Outputs hold while idle.

The arithmetic result is checked only by the bench's scenarios. These cover:
- carry-out and borrow patterns for both operations;
- wrap-around at the word boundaries;
- restart attempts and mid-run changes to sub_i;
- back-to-back starts on the done cycle;
- reset in the middle of an operation.

// File: rtl/bsas_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the bit-serial adder-subtractor.
// Assumes: nothing beyond a single-bit operation select.
package bsas_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/bsas_operand_shifter.sv
`timescale 1ns/1ps
// Module: bsas_operand_shifter
// Holds one operand. Parallel load on load_i; on shift_i moves right by one
// place, filling the top with zero, and presents bit 0 as the current bit.
// Assumes: load_i has priority over shift_i; WIDTH >= 2.
module bsas_operand_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] value_i,
    output logic             lsb_o
);

    logic [WIDTH-1:0] word_q;

    // Operand storage: load, shift right, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= value_i;
        end else if (shift_i) begin
            word_q <= {1'b0, word_q[WIDTH-1:1]};
        end
    end

    assign lsb_o = word_q[0];

endmodule

// File: rtl/bsas_result_collector.sv
`timescale 1ns/1ps
// Module: bsas_result_collector
// Gathers sum bits. Each shift puts the new bit at the MSB and moves the rest
// right, so after WIDTH shifts the first bit sits at bit 0.
// Assumes: clear_i (start) has priority over shift_i; WIDTH >= 2.
module bsas_result_collector #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] word_q;

    // Result storage: clear on a new operation, shift in each sum bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clear_i) begin
            word_q <= '0;
        end else if (shift_i) begin
            word_q <= {bit_i, word_q[WIDTH-1:1]};
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/bsas_bit_alu.sv
`timescale 1ns/1ps
// Module: bsas_bit_alu
// One full adder fed by an AND-OR selector. One AND passes the true Y bit
// when adding and the other passes the inverted Y bit when subtracting; an OR
// merges them. Purely combinational.
// Assumes: the two's-complement +1 comes from the carry preset elsewhere.
module bsas_bit_alu
    import bsas_pkg::*;
(
    input  op_e  op_i,
    input  logic x_bit_i,
    input  logic y_bit_i,
    input  logic carry_i,
    output logic sum_o,
    output logic carry_o
);

    logic add_leg;
    logic sub_leg;
    logic y_sel;

    // Operand selector: two AND legs merged by an OR.
    always_comb begin
        add_leg = (op_i == OP_ADD) &  y_bit_i;
        sub_leg = (op_i == OP_SUB) & ~y_bit_i;
        y_sel   = add_leg | sub_leg;
    end

    // Full adder on the current bit pair and the stored carry.
    always_comb begin
        sum_o   = x_bit_i ^ y_sel ^ carry_i;
        carry_o = (x_bit_i & y_sel) | (x_bit_i & carry_i) | (y_sel & carry_i);
    end

endmodule

// File: rtl/bsas_seq_ctrl.sv
`timescale 1ns/1ps
// Module: bsas_seq_ctrl
// Sequencer: accepts start when idle, latches the operation, presets the
// carry flip-flop (0 add, 1 subtract), counts WIDTH shift cycles and pulses
// done for one cycle after the last one.
// Assumes: start while busy is dropped; WIDTH >= 2.
module bsas_seq_ctrl
    import bsas_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  op_e  op_i,
    input  logic carry_next_i,
    output logic load_o,
    output logic shift_o,
    output op_e  op_o,
    output logic carry_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic             busy_q;
    logic             done_q;
    logic             carry_q;
    op_e              op_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;

    assign accept = start_i && !busy_q;

    // Sequencing, operation latch, carry flip-flop and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            carry_q <= 1'b0;
            op_q    <= OP_ADD;
            cnt_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                op_q    <= op_i;
                carry_q <= (op_i == OP_SUB);
                cnt_q   <= '0;
            end else if (busy_q) begin
                carry_q <= carry_next_i;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign load_o  = accept;
    assign shift_o = busy_q;
    assign op_o    = op_q;
    assign carry_o = carry_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;

endmodule

// File: rtl/bit_serial_addsub.sv
`timescale 1ns/1ps
// Module: bit_serial_addsub (top)
// Bit-serial adder-subtractor: two operand shifters, one full-adder slice
// with an add/subtract selector, a result collector and a sequencer.
// Assumes: WIDTH >= 2; result and carry are meaningful from done onward.
module bit_serial_addsub
    import bsas_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sub_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             done_o
);

    logic load;
    logic shift;
    logic busy;
    op_e  op_q;
    logic carry_q;
    logic x_bit;
    logic y_bit;
    logic sum_bit;
    logic carry_next;

    bsas_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_i         (op_e'(sub_i)),
        .carry_next_i (carry_next),
        .load_o       (load),
        .shift_o      (shift),
        .op_o         (op_q),
        .carry_o      (carry_q),
        .busy_o       (busy),
        .done_o       (done_o)
    );

    bsas_operand_shifter #(.WIDTH(WIDTH)) u_x_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .value_i (x_i),
        .lsb_o   (x_bit)
    );

    bsas_operand_shifter #(.WIDTH(WIDTH)) u_y_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .value_i (y_i),
        .lsb_o   (y_bit)
    );

    bsas_bit_alu u_alu (
        .op_i    (op_q),
        .x_bit_i (x_bit),
        .y_bit_i (y_bit),
        .carry_i (carry_q),
        .sum_o   (sum_bit),
        .carry_o (carry_next)
    );

    bsas_result_collector #(.WIDTH(WIDTH)) u_res_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .shift_i (shift),
        .bit_i   (sum_bit),
        .word_o  (result_o)
    );

    assign carry_o = carry_q;

endmodule

// File: rtl/bsas_chk.sv
`timescale 1ns/1ps
// Module: bsas_chk
// Protocol checker bound to bit_serial_addsub. Tracks cycles since the
// accepted start with its own counter.
// Assumes: synchronous active-low reset.
module bsas_chk
    import bsas_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             done_o,
    input logic             busy,
    input op_e              op_q
);

    logic [31:0] cyc_q;

    // Cycle count since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (start_i && !busy) begin
            cyc_q <= '0;
        end else if (busy) begin
            cyc_q <= cyc_q + 1;
        end
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cyc_q == 32'(WIDTH));

    p_busy_to_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> (busy || done_o));

    p_carry_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> carry_o == $past(sub_i));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> ($stable(result_o) && $stable(carry_o)));

    p_op_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_i) |=> (!busy || $stable(op_q)));

endmodule

bind bit_serial_addsub bsas_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sub_i    (sub_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .done_o   (done_o),
    .busy     (busy),
    .op_q     (op_q)
);

// File: tb/bit_serial_addsub_tb.sv
`timescale 1ns/1ps
module bit_serial_addsub_tb;

    localparam int W = 8;
    localparam int NVEC = 10;
    // {sub, x, y, expected result, expected carry}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
        {1'b0, 8'h5A, 8'h33, 8'h8D, 1'b0},
        {1'b0, 8'hFF, 8'h01, 8'h00, 1'b1},
        {1'b0, 8'h80, 8'h80, 8'h00, 1'b1},
        {1'b0, 8'hC8, 8'h64, 8'h2C, 1'b1},
        {1'b1, 8'h57, 8'h2E, 8'h29, 1'b1},
        {1'b1, 8'h36, 8'h4B, 8'hEB, 1'b0},
        {1'b1, 8'h00, 8'h00, 8'h00, 1'b1},
        {1'b1, 8'h00, 8'h01, 8'hFF, 1'b0},
        {1'b1, 8'h80, 8'h7F, 8'h01, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         sub_i = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [W-1:0] result_o;
    logic         carry_o;
    logic         done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bit_serial_addsub #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sub_i    (sub_i),
        .x_i      (x_i),
        .y_i      (y_i),
        .result_o (result_o),
        .carry_o  (carry_o),
        .done_o   (done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Waits for done at negedges; returns the number of negedges taken.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done_o && n < 100);
    endtask

    task automatic launch(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        start_i = 1'b1; sub_i = s; x_i = x; y_i = y;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 result", 32'(result_o), 32'h0);
        check("R1 carry", 32'(carry_o), 32'h0);
        check("R1 done", 32'(done_o), 32'h0);
        rst_n = 1'b1;

        // Vector table: R2 add, R3 subtract, R4 timing and pulse width
        for (int i = 0; i < NVEC; i++) begin
            launch(VEC[i][25], VEC[i][24:17], VEC[i][16:9]);
            wait_done(n);
            // launch consumed the first negedge after the start edge
            check(VEC[i][25] ? "R3 result" : "R2 result", 32'(result_o), 32'(VEC[i][8:1]));
            check(VEC[i][25] ? "R3 carry" : "R2 carry", 32'(carry_o), 32'(VEC[i][0]));
            check("R4 done latency", 32'(n + 1), 32'(W + 1));
            @(negedge clk);
            check("R4 done one cycle", 32'(done_o), 32'h0);
        end

        // R5: start while busy ignored
        launch(1'b0, 8'h12, 8'h34);
        repeat (2) @(negedge clk);
        start_i = 1'b1; sub_i = 1'b1; x_i = 8'hFF; y_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(n);
        check("R5 done timing", 32'(n + 4), 32'(W + 1));
        check("R5 result", 32'(result_o), 32'h46);
        check("R5 carry", 32'(carry_o), 32'h0);

        // R6: outputs hold while idle
        repeat (3) @(negedge clk);
        x_i = 8'hAA; y_i = 8'h55; sub_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 result hold", 32'(result_o), 32'h46);
        check("R6 carry hold", 32'(carry_o), 32'h0);

        // R8: sub_i changed mid-operation has no effect
        launch(1'b1, 8'h10, 8'h01);
        sub_i = 1'b0;
        wait_done(n);
        check("R8 result", 32'(result_o), 32'h0F);
        check("R8 carry", 32'(carry_o), 32'h1);

        // R7: start on the done cycle is accepted
        launch(1'b0, 8'h01, 8'h02);
        wait_done(n);
        start_i = 1'b1; sub_i = 1'b0; x_i = 8'hF0; y_i = 8'h20;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(n);
        check("R7 back-to-back latency", 32'(n + 1), 32'(W + 1));
        check("R7 result", 32'(result_o), 32'h10);
        check("R7 carry", 32'(carry_o), 32'h1);

        // R1: reset in the middle of an operation clears outputs
        launch(1'b1, 8'h00, 8'h01);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-op result", 32'(result_o), 32'h0);
        check("R1 mid-op carry", 32'(carry_o), 32'h0);
        rst_n = 1'b1;
        repeat (W + 2) @(negedge clk);
        check("R1 no done after reset", 32'(done_o), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule